// File: doc/BRIEF.md
# Serial-Mode Bus Multiplexer for a Link-Side Transceiver Port

This block sits between the eight-bit data bus of a USB transceiver's link-side port and the transceiver's line logic. In normal operation it passes through the values of the synchronous protocol engine. When the link asks for one of the two legacy full/low-speed serial modes, the block takes over the bus. It gives each data pin a fixed job: transmit enable, transmit data, single-ended zero, a latched interrupt, or a receive level. It also drives every pin's output enable.

In the six-pin variant the pin directions are fixed. In the three-pin variant the data pin and the single-ended-zero pin turn around in the same cycle that transmit enable changes. The link leaves either serial mode by raising STP. The block then pulses a strobe so the register file clears its mode bits. While chip select is inactive, the block floats the whole port, enables the pull-downs, and ignores every command.

Top module: `ulpi_serial_mux`

## Requirements
- R1: While `chipSelN` is high, `dataOe` is 0x00. `dirOe`, `nxtOe` and `clkOe` are low, `pullDownEn` is high, and `txEn`, `txDat` and `txSe0` are low, all in the same cycle.
- R2: While `chipSelN` is high, rising mode bits and STP have no effect. Once chip select returns, the port is in synchronous mode and stays there until a mode bit rises again.
- R3: A rising edge of `reqSixPin` or `reqThreePin` while selected and in synchronous mode enters that serial mode at the next clock. In serial mode `dirOut` is 1 and `nxtOut` is 0. If both bits rise in the same cycle, the six-pin mode is entered.
- R4: In six-pin mode, `dataIn` bits 0, 1 and 2 drive `txEn`, `txDat` and `txSe0`. `dataOe` is 0xF8. `dataOut` bits 4, 5 and 6 carry `rxDp`, `rxDm` and `rxDiff`, and bit 7 is 0.
- R5: In three-pin mode, `txEn` follows `dataIn` bit 0. `dataOe` bits 7..3 are 1 and bit 0 is 0. `dataOut` bits 7..4 are 0.
- R6: In three-pin mode with `dataIn[0]` high, `dataOe` bits 1 and 2 are 0 in that same cycle, and `txDat` and `txSe0` follow `dataIn` bits 1 and 2. With `dataIn[0]` low, those enables are 1, `dataOut` bits 1 and 2 carry `rxDiff` and `rxSe0`, and `txDat` and `txSe0` are 0.
- R7: In either serial mode, `dataOut` bit 3 is an interrupt latch. The latch sets at the clock after any `intEvents` bit is high while the matching `intMask` bit is 0, and it holds after the event goes away. A mask bit of 1 blocks its event.
- R8: `intClr` clears the latch at the next clock. If an unmasked event arrives in the same cycle as the clear, the latch stays set.
- R9: STP high in a serial mode returns the port to synchronous mode at the next clock, with `dirOut` following `syncDir`. It also clears the interrupt latch, even against a simultaneous event, and raises `modeBitsClr` for exactly one cycle.
- R10: In synchronous mode, `dataOut` equals `syncDataOut`. Every `dataOe` bit equals `syncDataOe`, `dirOut` and `nxtOut` follow `syncDir` and `syncNxt`, and the transmit requests are low.
- R11: A mode bit that stays high after an exit does not re-enter serial mode. It must fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Active-low reset |
| chipSelN | input | 1 | Active-low chip select; high means power-down |
| stp | input | 1 | Stop signal from the link |
| reqSixPin | input | 1 | Six-pin serial mode bit from the control register |
| reqThreePin | input | 1 | Three-pin serial mode bit from the control register |
| modeBitsClr | output | 1 | One-cycle strobe that clears the register mode bits |
| dataIn | input | 8 | Data bus as seen at the pads |
| dataOut | output | 8 | Data bus drive values |
| dataOe | output | 8 | Per-pin output enables |
| dirOut | output | 1 | Direction pin value |
| dirOe | output | 1 | Direction pin output enable |
| nxtOut | output | 1 | Next pin value |
| nxtOe | output | 1 | Next pin output enable |
| clkOe | output | 1 | Clock output enable |
| pullDownEn | output | 1 | Weak pull-down enable for the bus pins |
| syncDataOut | input | 8 | Synchronous engine data |
| syncDataOe | input | 1 | Synchronous engine bus enable |
| syncDir | input | 1 | Synchronous engine direction |
| syncNxt | input | 1 | Synchronous engine next |
| rxDp | input | 1 | Single-ended DP receive level |
| rxDm | input | 1 | Single-ended DM receive level |
| rxDiff | input | 1 | Differential receive data |
| rxSe0 | input | 1 | Received single-ended zero |
| txEn | output | 1 | Line transmit enable request |
| txDat | output | 1 | Line transmit data request |
| txSe0 | output | 1 | Line transmit SE0 request |
| intEvents | input | INT_W | Interrupt event sources |
| intMask | input | INT_W | Interrupt masks, 1 blocks |
| intClr | input | 1 | Read-clear strobe for the interrupt latch |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the interrupt latch's read-clear strobe and a new unmasked event. The second pair is an STP exit and an unmasked event. The bench drives each pair at one falling edge. For the first pair, it expects data bit 3 to stay high at the next sample. For the second pair, it expects the latch to be empty when serial mode is re-entered, and the clear strobe to last one cycle. The three-pin turnaround is judged in the same cycle as the transmit-enable change. This confirms that the block releases the pins before the link drives them.

// File: rtl/ulpi_serial_pkg.sv
package ulpi_serial_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC  = 2'd0,
    MODE_SIX   = 2'd1,
    MODE_THREE = 2'd2
  } busMode_e;

  // strobes from the control FSM to the pin datapath
  typedef struct packed {
    logic powerDown;
    logic sixPin;
    logic threePin;
    logic exitSerial;
  } ctrlStrobe_t;

  localparam int BUS_W      = 8;
  localparam int PIN_TXEN   = 0;
  localparam int PIN_DAT    = 1;
  localparam int PIN_SE0    = 2;
  localparam int PIN_INT    = 3;
  localparam int PIN_RXDP   = 4;
  localparam int PIN_RXDM   = 5;
  localparam int PIN_RXDIFF = 6;
  localparam int RSV_LO3    = 3;

endpackage

// File: rtl/ulpi_serial_ctrl.sv
module ulpi_serial_ctrl
  import ulpi_serial_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSelN,
  input  logic        stp,
  input  logic        reqSixPin,
  input  logic        reqThreePin,
  output ctrlStrobe_t strobe,
  output logic        modeBitsClr
);

  busMode_e modeQ, modeD;
  logic sixPrevQ, threePrevQ;
  logic sixRise, threeRise, powerDown, exitSerial;

  assign powerDown  = chipSelN;
  assign sixRise    = reqSixPin & ~sixPrevQ;
  assign threeRise  = reqThreePin & ~threePrevQ;
  assign exitSerial = !powerDown && stp && (modeQ != MODE_SYNC);

  always_comb begin
    modeD = modeQ;
    if (powerDown) begin
      modeD = MODE_SYNC;
    end else begin
      case (modeQ)
        MODE_SYNC: begin
          if (sixRise)        modeD = MODE_SIX;
          else if (threeRise) modeD = MODE_THREE;
        end
        default: begin
          if (stp) modeD = MODE_SYNC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_SYNC;
      sixPrevQ    <= 1'b0;
      threePrevQ  <= 1'b0;
      modeBitsClr <= 1'b0;
    end else begin
      modeQ       <= modeD;
      sixPrevQ    <= reqSixPin;
      threePrevQ  <= reqThreePin;
      modeBitsClr <= exitSerial;
    end
  end

  assign strobe.powerDown  = powerDown;
  assign strobe.sixPin     = !powerDown && (modeQ == MODE_SIX);
  assign strobe.threePin   = !powerDown && (modeQ == MODE_THREE);
  assign strobe.exitSerial = exitSerial;

  // R9: stop returns to synchronous mode one clock later
  a_r9_exit_to_sync: assert property (@(posedge clk) disable iff (!rstN)
    exitSerial |=> (modeQ == MODE_SYNC));

  // R9: the clear strobe never lasts two cycles
  a_r9_clr_single: assert property (@(posedge clk) disable iff (!rstN)
    modeBitsClr |=> !modeBitsClr);

  // R2: power-down leaves the mode register in synchronous mode
  a_r2_pd_sync: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (modeQ == MODE_SYNC));

  // R3: at most one serial mode is active
  a_r3_one_mode: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sixPin, strobe.threePin}));

endmodule

// File: rtl/ulpi_serial_path.sv
module ulpi_serial_path
  import ulpi_serial_pkg::*;
#(
  parameter int INT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        linkPins,
  input  logic              rxDp,
  input  logic              rxDm,
  input  logic              rxDiff,
  input  logic              rxSe0,
  input  logic [INT_W-1:0]  intEvents,
  input  logic [INT_W-1:0]  intMask,
  input  logic              intClr,
  input  logic [BUS_W-1:0]  syncDataOut,
  input  logic              syncDataOe,
  input  logic              syncDir,
  input  logic              syncNxt,
  output logic [BUS_W-1:0]  dataOut,
  output logic [BUS_W-1:0]  dataOe,
  output logic              dirOut,
  output logic              dirOe,
  output logic              nxtOut,
  output logic              nxtOe,
  output logic              clkOe,
  output logic              pullDownEn,
  output logic              txEn,
  output logic              txDat,
  output logic              txSe0
);

  logic intLatchQ, serialOn, unmaskedHit;

  assign serialOn    = strobe.sixPin | strobe.threePin;
  assign unmaskedHit = |(intEvents & ~intMask);

  // interrupt latch: exit wins, then a new event, then the read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intLatchQ <= 1'b0;
    end else if (!serialOn || strobe.exitSerial) begin
      intLatchQ <= 1'b0;
    end else if (unmaskedHit) begin
      intLatchQ <= 1'b1;
    end else if (intClr) begin
      intLatchQ <= 1'b0;
    end
  end

  assign pullDownEn = strobe.powerDown;
  assign dirOe      = !strobe.powerDown;
  assign nxtOe      = !strobe.powerDown;
  assign clkOe      = !strobe.powerDown;

  always_comb begin
    dataOut = '0;
    dataOe  = '0;
    dirOut  = 1'b0;
    nxtOut  = 1'b0;
    txEn    = 1'b0;
    txDat   = 1'b0;
    txSe0   = 1'b0;
    if (strobe.powerDown) begin
      dataOe = '0;
    end else if (strobe.sixPin) begin
      dirOut              = 1'b1;
      dataOe[BUS_W-1:RSV_LO3] = '1;
      dataOut[PIN_INT]    = intLatchQ;
      dataOut[PIN_RXDP]   = rxDp;
      dataOut[PIN_RXDM]   = rxDm;
      dataOut[PIN_RXDIFF] = rxDiff;
      txEn                = linkPins[PIN_TXEN];
      txDat               = linkPins[PIN_DAT];
      txSe0               = linkPins[PIN_SE0];
    end else if (strobe.threePin) begin
      dirOut                  = 1'b1;
      dataOe[BUS_W-1:RSV_LO3] = '1;
      dataOut[PIN_INT]        = intLatchQ;
      txEn                    = linkPins[PIN_TXEN];
      if (linkPins[PIN_TXEN]) begin
        txDat = linkPins[PIN_DAT];
        txSe0 = linkPins[PIN_SE0];
      end else begin
        dataOe[PIN_DAT]  = 1'b1;
        dataOe[PIN_SE0]  = 1'b1;
        dataOut[PIN_DAT] = rxDiff;
        dataOut[PIN_SE0] = rxSe0;
      end
    end else begin
      dataOut = syncDataOut;
      dataOe  = {BUS_W{syncDataOe}};
      dirOut  = syncDir;
      nxtOut  = syncNxt;
    end
  end

  // R6: block releases the turnaround pins when the link transmits
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.threePin && linkPins[PIN_TXEN]) |-> (dataOe[PIN_SE0:PIN_DAT] == 2'b00));

  // R7: an unmasked event sets the latch at the next clock
  a_r7_int_set: assert property (@(posedge clk) disable iff (!rstN)
    (serialOn && !strobe.exitSerial && unmaskedHit) |=> intLatchQ);

  // R9: leaving serial mode empties the latch
  a_r9_int_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exitSerial |=> !intLatchQ);

  // R1: nothing driven during power-down
  a_r1_float: assert property (@(posedge clk) disable iff (!rstN)
    strobe.powerDown |-> (dataOe == '0 && !txEn && pullDownEn));

endmodule

// File: rtl/ulpi_serial_mux.sv
module ulpi_serial_mux
  import ulpi_serial_pkg::*;
#(
  parameter int INT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             stp,
  input  logic             reqSixPin,
  input  logic             reqThreePin,
  output logic             modeBitsClr,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic [7:0]       dataOe,
  output logic             dirOut,
  output logic             dirOe,
  output logic             nxtOut,
  output logic             nxtOe,
  output logic             clkOe,
  output logic             pullDownEn,
  input  logic [7:0]       syncDataOut,
  input  logic             syncDataOe,
  input  logic             syncDir,
  input  logic             syncNxt,
  input  logic             rxDp,
  input  logic             rxDm,
  input  logic             rxDiff,
  input  logic             rxSe0,
  output logic             txEn,
  output logic             txDat,
  output logic             txSe0,
  input  logic [INT_W-1:0] intEvents,
  input  logic [INT_W-1:0] intMask,
  input  logic             intClr
);

  ctrlStrobe_t strobe;
  logic unusedHiPins;

  // upper pins are only ever outputs of this block
  assign unusedHiPins = ^dataIn[7:3];

  ulpi_serial_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chipSelN    (chipSelN),
    .stp         (stp),
    .reqSixPin   (reqSixPin),
    .reqThreePin (reqThreePin),
    .strobe      (strobe),
    .modeBitsClr (modeBitsClr)
  );

  ulpi_serial_path #(.INT_W(INT_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .linkPins    (dataIn[2:0]),
    .rxDp        (rxDp),
    .rxDm        (rxDm),
    .rxDiff      (rxDiff),
    .rxSe0       (rxSe0),
    .intEvents   (intEvents),
    .intMask     (intMask),
    .intClr      (intClr),
    .syncDataOut (syncDataOut),
    .syncDataOe  (syncDataOe),
    .syncDir     (syncDir),
    .syncNxt     (syncNxt),
    .dataOut     (dataOut),
    .dataOe      (dataOe),
    .dirOut      (dirOut),
    .dirOe       (dirOe),
    .nxtOut      (nxtOut),
    .nxtOe       (nxtOe),
    .clkOe       (clkOe),
    .pullDownEn  (pullDownEn),
    .txEn        (txEn),
    .txDat       (txDat),
    .txSe0       (txSe0)
  );

endmodule

// File: tb/ulpi_serial_mux_test.sv
module ulpi_serial_mux_test;

  localparam int INT_W = 5;

  logic clk = 1'b0;
  logic rstN, chipSelN, stp, reqSixPin, reqThreePin, modeBitsClr;
  logic [7:0] dataIn, dataOut, dataOe, syncDataOut;
  logic dirOut, dirOe, nxtOut, nxtOe, clkOe, pullDownEn;
  logic syncDataOe, syncDir, syncNxt;
  logic rxDp, rxDm, rxDiff, rxSe0, txEn, txDat, txSe0, intClr;
  logic [INT_W-1:0] intEvents, intMask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ulpi_serial_mux #(.INT_W(INT_W)) uut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .stp(stp),
    .reqSixPin(reqSixPin), .reqThreePin(reqThreePin), .modeBitsClr(modeBitsClr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .dirOut(dirOut), .dirOe(dirOe), .nxtOut(nxtOut), .nxtOe(nxtOe),
    .clkOe(clkOe), .pullDownEn(pullDownEn),
    .syncDataOut(syncDataOut), .syncDataOe(syncDataOe), .syncDir(syncDir), .syncNxt(syncNxt),
    .rxDp(rxDp), .rxDm(rxDm), .rxDiff(rxDiff), .rxSe0(rxSe0),
    .txEn(txEn), .txDat(txDat), .txSe0(txSe0),
    .intEvents(intEvents), .intMask(intMask), .intClr(intClr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs change at the falling edge; outputs are sampled 2 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic exitSerial();
    step(); stp = 1'b1;
    step(); stp = 1'b0;
  endtask

  task automatic testReset();
    settle();
    check("R10 reset dirOut", dirOut, 0);
    check("R10 reset dataOe", dataOe, 8'h00);
    check("R1 reset pullDownEn", pullDownEn, 0);
    check("R1 reset dirOe/nxtOe/clkOe", {dirOe, nxtOe, clkOe}, 3'b111);
  endtask

  task automatic testSync();
    step(); syncDataOut = 8'hA5; syncDataOe = 1'b1; syncDir = 1'b1; syncNxt = 1'b1; dataIn = 8'h07;
    settle();
    check("R10 sync dataOut", dataOut, 8'hA5);
    check("R10 sync dataOe", dataOe, 8'hFF);
    check("R10 sync dir/nxt", {dirOut, nxtOut}, 2'b11);
    check("R10 sync tx low", {txEn, txDat, txSe0}, 3'b000);
    step(); syncDataOut = 8'h00; syncDataOe = 1'b0; syncDir = 1'b0; syncNxt = 1'b0; dataIn = 8'h00;
  endtask

  task automatic testSixPin();
    step(); reqSixPin = 1'b1;
    step(); settle();
    check("R3 six entry dir/nxt", {dirOut, nxtOut}, 2'b10);
    check("R4 six dataOe", dataOe, 8'hF8);
    dataIn = 8'h05; rxDp = 1'b1; rxDm = 1'b0; rxDiff = 1'b1;
    settle();
    check("R4 six tx pattern A", {txEn, txDat, txSe0}, 3'b101);
    check("R4 six dataOut pattern A", dataOut, 8'h50);
    step(); dataIn = 8'h02; rxDp = 1'b0; rxDm = 1'b1; rxDiff = 1'b0;
    settle();
    check("R4 six tx pattern B", {txEn, txDat, txSe0}, 3'b010);
    check("R4 six dataOut pattern B", dataOut, 8'h20);
    step(); dataIn = 8'h00; rxDm = 1'b0;
  endtask

  task automatic testInterrupt();
    step(); intMask = 5'b11110; intEvents = 5'b00010;
    step(); intEvents = '0; settle();
    check("R7 masked event ignored", dataOut[3], 0);
    intEvents = 5'b00001;
    step(); intEvents = '0; settle();
    check("R7 unmasked event sets", dataOut[3], 1);
    step(); settle();
    check("R7 latch holds", dataOut[3], 1);
    intClr = 1'b1;
    step(); intClr = 1'b0; settle();
    check("R8 clear strobe", dataOut[3], 0);
    intClr = 1'b1; intEvents = 5'b00001;
    step(); intClr = 1'b0; intEvents = '0; settle();
    check("R8 event beats clear", dataOut[3], 1);
  endtask

  task automatic testExit();
    // latch is set; stop and a fresh event together
    step(); stp = 1'b1; intEvents = 5'b00001;
    step(); stp = 1'b0; intEvents = '0; settle();
    check("R9 exit dirOut", dirOut, 0);
    check("R9 exit clear strobe", modeBitsClr, 1);
    step(); settle();
    check("R9 clear strobe single", modeBitsClr, 0);
    step(); settle();
    check("R11 held bit no re-entry", dirOut, 0);
    reqSixPin = 1'b0;
    step(); reqSixPin = 1'b1;
    step(); settle();
    check("R11 re-entry after new rise", dirOut, 1);
    check("R9 latch empty after exit", dataOut[3], 0);
    exitSerial();
    reqSixPin = 1'b0;
  endtask

  task automatic testThreePin();
    step(); reqThreePin = 1'b1; dataIn = 8'h00; rxDiff = 1'b1; rxSe0 = 1'b0;
    step(); settle();
    check("R5 three dataOe receive", dataOe, 8'hFE);
    check("R6 three receive dataOut", dataOut & 8'hF6, 8'h02);
    check("R6 three receive tx", {txEn, txDat, txSe0}, 3'b000);
    rxDiff = 1'b0; rxSe0 = 1'b1; settle();
    check("R6 three receive se0", dataOut & 8'hF6, 8'h04);
    dataIn = 8'h07; settle();
    check("R6 three turnaround same cycle", dataOe, 8'hF8);
    check("R6 three tx pattern A", {txEn, txDat, txSe0}, 3'b111);
    step(); dataIn = 8'h05; settle();
    check("R5 three tx pattern B", {txEn, txDat, txSe0}, 3'b101);
    check("R5 three upper pins low", dataOut[7:4], 4'h0);
    step(); dataIn = 8'h00;
    exitSerial();
    reqThreePin = 1'b0;
    step(); settle();
    check("R9 three exit dirOut", dirOut, 0);
  endtask

  task automatic testBothRise();
    step(); reqSixPin = 1'b1; reqThreePin = 1'b1; dataIn = 8'h00;
    step(); settle();
    check("R3 both rise picks six", dataOe, 8'hF8);
    exitSerial();
    reqSixPin = 1'b0; reqThreePin = 1'b0;
  endtask

  task automatic testPowerDown();
    step(); reqThreePin = 1'b1;
    step(); reqThreePin = 1'b0; dataIn = 8'h07; chipSelN = 1'b1; settle();
    check("R1 pd dataOe", dataOe, 8'h00);
    check("R1 pd dir/nxt/clk oe", {dirOe, nxtOe, clkOe}, 3'b000);
    check("R1 pd pullDownEn", pullDownEn, 1);
    check("R1 pd tx low", {txEn, txDat, txSe0}, 3'b000);
    step(); reqSixPin = 1'b1; stp = 1'b1;
    step(); stp = 1'b0; chipSelN = 1'b0; dataIn = 8'h00; settle();
    check("R2 wake in sync mode", {dirOut, dataOe}, 9'h000);
    step(); settle();
    check("R2 command during pd ignored", dirOut, 0);
    reqSixPin = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; chipSelN = 1'b0; stp = 1'b0; reqSixPin = 1'b0; reqThreePin = 1'b0;
    dataIn = '0; syncDataOut = '0; syncDataOe = 1'b0; syncDir = 1'b0; syncNxt = 1'b0;
    rxDp = 1'b0; rxDm = 1'b0; rxDiff = 1'b0; rxSe0 = 1'b0;
    intEvents = '0; intMask = '0; intClr = 1'b0;
    step(); step();
    testReset();
    rstN = 1'b1;
    testSync();
    testSixPin();
    testInterrupt();
    testExit();
    testThreePin();
    testBothRise();
    testPowerDown();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule